// File: doc/BRIEF.md
# DRAM Strobe Timing Sequencer

This block sits between a slow processor and an asynchronous DRAM. It runs on a clock many times faster than the processor. From one access strobe it builds three active-high controls for the DRAM:

- the row strobe;
- the row/column select for the address multiplexer;
- the column strobe.

A thermometer-style shift register fills with ones from the moment a request is accepted, so each of its bits is a copy of the row strobe delayed by a fixed number of fast ticks. Fixed taps of that register time the edges. The read/write level picks between a read column-strobe tap and a later write tap, which gives write data time to settle. The selected taps are registered before they reach the pins, so the pins carry no glitches.

After every cycle the sequencer enforces a precharge gap, with a busy flag held high for its whole length. A refresh request is served only between cycles. A refresh is a row-strobe-only cycle that drives the row from an internal counter; the counter then advances and wraps. A strobe edge that arrives while the sequencer is busy, or in the same tick as a refresh request, is remembered and served as soon as the precharge gap ends.

Timing convention used below: the "accepting edge" is the clock edge at which a request is taken. Tick n is the output state after the n-th edge following the accepting edge, so the accepting edge itself gives tick 0. An access request is a strobe edge: `strobe_i` sampled high at an edge after it was sampled low at the previous edge. The figures below use the default parameters: row tap 0, select tap 2, read column tap 4, write column tap 5, end tap 12, gap 3 ticks, address width 8.

Top module: `dram_strobe_seq`

## Requirements
- R1: With reset high, and in the first tick after it, `ras_o`, `mux_o`, `cas_o` and `busy_o` are 0. The refresh row counter restarts at 0, so the first refresh drives row 0.
- R2: A strobe edge seen while idle is accepted at that edge. `ras_o` is 1 from tick 0 to tick 11, and `dram_addr_o` shows `row_i` from tick 0. Holding `strobe_i` high starts no further cycle.
- R3: `mux_o` is 1 from tick 2 to tick 11, and `dram_addr_o` shows `col_i` while `mux_o` is 1. `mux_o` is never 1 while `ras_o` is 0, and it only rises one or more ticks after `ras_o`.
- R4: `cas_o` is 1 from tick 4 to tick 11 on a read (`rw_i`=1 at the strobe edge) and from tick 5 to tick 11 on a write (`rw_i`=0). `cas_o` is never 1 while `mux_o` is 0.
- R5: At tick 12 `ras_o`, `mux_o` and `cas_o` fall together, and `dram_addr_o` returns to the row address.
- R6: `busy_o` is 1 from tick 0 to tick 14. It is 0 at tick 15 when no request is waiting. `ras_o` is never 1 while `busy_o` is 0.
- R7: `ras_o` stays low for at least 3 ticks between cycles. A strobe edge seen while busy is remembered, with its address and read/write level. It is accepted at tick 15 of the running cycle, so its own tick 0 is that cycle's tick 15.
- R8: A refresh request accepted while idle runs a row-only cycle: `ras_o` is 1 from tick 0 to tick 11, `mux_o` and `cas_o` stay 0, and `dram_addr_o` shows the refresh row for all 15 ticks.
- R9: After each refresh cycle the refresh row goes up by one, wrapping from 255 to 0 (modulo 2^ADDR_W).
- R10: When a strobe edge and a refresh request arrive at the same edge, the refresh runs first. The processor access then starts at the refresh's tick 15.
- R11: A refresh request raised during a processor cycle is not served until that cycle's tick 15. It is accepted there if it is still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Processor memory-access strobe, active high, edge-triggered |
| rw_i | input | 1 | 1 = read, 0 = write, sampled at the strobe edge |
| refresh_req_i | input | 1 | Refresh request, level, served between cycles |
| row_i | input | ADDR_W | Processor row address, sampled at the strobe edge |
| col_i | input | ADDR_W | Processor column address, sampled at the strobe edge |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| mux_o | output | 1 | Address select: 0 = row, 1 = column |
| dram_addr_o | output | ADDR_W | Multiplexed DRAM address |
| busy_o | output | 1 | High from acceptance until the precharge gap ends |

## Verification
The bench aims at the tap boundaries:

- **Column-strobe tap.** Ticks 4 and 5 are checked on both reads and writes. A design that ignored the read/write level would show its column strobe one tick early on writes, or one tick late on reads.
- **Back-to-back requests.** A strobe edge arriving mid-cycle, and a strobe arriving with a refresh in the same tick, must each begin exactly at tick 15. Dropping the remembered request loses the access. Starting it early squeezes the precharge gap. Letting the access beat the refresh swaps the two address sequences.
- **Refresh row wrap.** A full lap of 256 refreshes exposes a row counter that does not wrap, or that advances before its row has been driven.
- **Held strobe.** A strobe held high past the end of a cycle catches a level-triggered design, which would start a second, spurious cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic {
        CYC_CPU = 1'b0,
        CYC_REF = 1'b1
    } cyc_kind_e;

    // Raw taps of the delay register, taken from its next state.
    typedef struct packed {
        logic ras;
        logic mux;
        logic cas_rd;
        logic cas_wr;
        logic fin;
        logic busy;
    } tap_bank_t;

    // Control levels presented to the DRAM.
    typedef struct packed {
        logic ras;
        logic mux;
        logic cas;
        logic busy;
    } strobe_set_t;

    // A tap level that opens at its own tap and closes at the end tap.
    function automatic logic tap_window(input logic open_tap, input logic end_tap);
        return open_tap & ~end_tap;
    endfunction

    // The read/write level picks the column-strobe tap.
    function automatic logic pick_cas(input logic is_read, input logic rd_tap, input logic wr_tap);
        return is_read ? rd_tap : wr_tap;
    endfunction

endpackage

// File: rtl/seq_shift.sv
module seq_shift
    import dram_seq_pkg::*;
#(
    parameter int unsigned RAS_T    = 0,
    parameter int unsigned MUX_T    = 2,
    parameter int unsigned CAS_RD_T = 4,
    parameter int unsigned CAS_WR_T = 5,
    parameter int unsigned END_T    = 12,
    parameter int unsigned LEN      = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      idle_ok,
    output logic      at_last,
    output tap_bank_t taps_n
);

    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] sr_n;

    // Fills with ones from bit 0 upward; bit k is the row strobe delayed by k ticks.
    always_comb begin
        if (start) begin
            sr_n = {{(LEN-1){1'b0}}, 1'b1};
        end else if (sr_q[LEN-1]) begin
            sr_n = '0;
        end else if (sr_q[0]) begin
            sr_n = {sr_q[LEN-2:0], 1'b1};
        end else begin
            sr_n = sr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_n;
        end
    end

    // Idle, or in the last gap tick, where a new cycle may chain directly.
    assign idle_ok = ~sr_q[0] | sr_q[LEN-1];
    assign at_last = sr_q[LEN-1];

    assign taps_n.ras    = sr_n[RAS_T];
    assign taps_n.mux    = sr_n[MUX_T];
    assign taps_n.cas_rd = sr_n[CAS_RD_T];
    assign taps_n.cas_wr = sr_n[CAS_WR_T];
    assign taps_n.fin    = sr_n[END_T];
    assign taps_n.busy   = sr_n[0];

endmodule

// File: rtl/seq_tap_select.sv
module seq_tap_select
    import dram_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tap_bank_t   taps_n,
    input  cyc_kind_e   kind_n,
    input  logic        read_n,
    output logic        mux_n,
    output logic        busy_n,
    output strobe_set_t set_q
);

    strobe_set_t cpu_set;
    strobe_set_t ref_set;
    strobe_set_t set_n;

    always_comb begin
        cpu_set.ras  = tap_window(taps_n.ras, taps_n.fin);
        cpu_set.mux  = tap_window(taps_n.mux, taps_n.fin);
        cpu_set.cas  = tap_window(pick_cas(read_n, taps_n.cas_rd, taps_n.cas_wr), taps_n.fin);
        cpu_set.busy = taps_n.busy;

        ref_set.ras  = tap_window(taps_n.ras, taps_n.fin);
        ref_set.mux  = 1'b0;
        ref_set.cas  = 1'b0;
        ref_set.busy = taps_n.busy;

        set_n = (kind_n == CYC_REF) ? ref_set : cpu_set;
    end

    assign mux_n  = set_n.mux;
    assign busy_n = set_n.busy;

    // Registered stage so the pins carry no decode glitches.
    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
        end else begin
            set_q <= set_n;
        end
    end

endmodule

// File: rtl/seq_ref_counter.sv
module seq_ref_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_n
);

    assign cnt_n = adv ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/seq_addr_mux.sv
module seq_addr_mux
    import dram_seq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  cyc_kind_e    kind_n,
    input  logic         mux_n,
    input  logic         busy_n,
    input  logic [W-1:0] row_n,
    input  logic [W-1:0] col_n,
    input  logic [W-1:0] ref_n,
    output logic [W-1:0] addr_q
);

    logic [W-1:0] addr_n;

    always_comb begin
        if (kind_n == CYC_REF) begin
            addr_n = ref_n;
        end else if (mux_n) begin
            addr_n = col_n;
        end else begin
            addr_n = row_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (busy_n) begin
            addr_q <= addr_n;
        end
    end

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned RAS_TICK    = 0,
    parameter int unsigned MUX_TICK    = 2,
    parameter int unsigned CAS_RD_TICK = 4,
    parameter int unsigned CAS_WR_TICK = 5,
    parameter int unsigned END_TICK    = 12,
    parameter int unsigned PRE_TICKS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic              rw_i,
    input  logic              refresh_req_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic [ADDR_W-1:0] col_i,
    output logic              ras_o,
    output logic              cas_o,
    output logic              mux_o,
    output logic [ADDR_W-1:0] dram_addr_o,
    output logic              busy_o
);

    localparam int unsigned SEQ_LEN = END_TICK + PRE_TICKS;

    logic strobe_q;
    logic rise;
    logic pending_q, pending_n;
    logic idle_ok, at_last, start, take_cpu;
    cyc_kind_e kind_q, kind_n;
    logic rw_lat_q, rw_q, rw_n, rw_eff;
    logic [ADDR_W-1:0] row_lat_q, col_lat_q;
    logic [ADDR_W-1:0] acc_row_q, acc_col_q, acc_row_n, acc_col_n;
    logic [ADDR_W-1:0] ref_q, ref_n;
    logic [ADDR_W-1:0] row_eff, col_eff;
    logic mux_n, busy_n;
    tap_bank_t   taps_n;
    strobe_set_t set_q;

    // Access requests are strobe edges, not levels.
    assign rise     = strobe_i & ~strobe_q;
    assign start    = idle_ok & (refresh_req_i | pending_q | rise);
    assign take_cpu = start & ~refresh_req_i;

    assign rw_eff  = rise ? rw_i  : rw_lat_q;
    assign row_eff = rise ? row_i : row_lat_q;
    assign col_eff = rise ? col_i : col_lat_q;

    always_comb begin
        kind_n    = kind_q;
        rw_n      = rw_q;
        acc_row_n = acc_row_q;
        acc_col_n = acc_col_q;
        if (start) begin
            kind_n = refresh_req_i ? CYC_REF : CYC_CPU;
        end
        if (take_cpu) begin
            rw_n      = rw_eff;
            acc_row_n = row_eff;
            acc_col_n = col_eff;
        end
        pending_n = (pending_q | rise) & ~take_cpu;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q  <= 1'b0;
            pending_q <= 1'b0;
            kind_q    <= CYC_CPU;
            rw_q      <= 1'b1;
            rw_lat_q  <= 1'b1;
            row_lat_q <= '0;
            col_lat_q <= '0;
            acc_row_q <= '0;
            acc_col_q <= '0;
        end else begin
            strobe_q  <= strobe_i;
            pending_q <= pending_n;
            kind_q    <= kind_n;
            rw_q      <= rw_n;
            acc_row_q <= acc_row_n;
            acc_col_q <= acc_col_n;
            if (rise) begin
                rw_lat_q  <= rw_i;
                row_lat_q <= row_i;
                col_lat_q <= col_i;
            end
        end
    end

    seq_shift #(
        .RAS_T   (RAS_TICK),
        .MUX_T   (MUX_TICK),
        .CAS_RD_T(CAS_RD_TICK),
        .CAS_WR_T(CAS_WR_TICK),
        .END_T   (END_TICK),
        .LEN     (SEQ_LEN)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .idle_ok(idle_ok),
        .at_last(at_last),
        .taps_n (taps_n)
    );

    seq_tap_select u_select (
        .clk   (clk),
        .rst   (rst),
        .taps_n(taps_n),
        .kind_n(kind_n),
        .read_n(rw_n),
        .mux_n (mux_n),
        .busy_n(busy_n),
        .set_q (set_q)
    );

    seq_ref_counter #(
        .W(ADDR_W)
    ) u_refcnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (at_last & (kind_q == CYC_REF)),
        .cnt_q(ref_q),
        .cnt_n(ref_n)
    );

    seq_addr_mux #(
        .W(ADDR_W)
    ) u_amux (
        .clk   (clk),
        .rst   (rst),
        .kind_n(kind_n),
        .mux_n (mux_n),
        .busy_n(busy_n),
        .row_n (acc_row_n),
        .col_n (acc_col_n),
        .ref_n (ref_n),
        .addr_q(dram_addr_o)
    );

    assign ras_o  = set_q.ras;
    assign mux_o  = set_q.mux;
    assign cas_o  = set_q.cas;
    assign busy_o = set_q.busy;

endmodule

// File: rtl/dram_strobe_seq_chk.sv
module dram_strobe_seq_chk #(
    parameter int unsigned PRE_TICKS = 3
) (
    input logic clk,
    input logic rst,
    input logic ras_o,
    input logic cas_o,
    input logic mux_o,
    input logic busy_o
);

    localparam int unsigned GW = $clog2(PRE_TICKS + 1) + 1;

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= GW'(PRE_TICKS);
        end else if (ras_o) begin
            gap_cnt <= '0;
        end else if (gap_cnt < GW'(PRE_TICKS)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ras_o && !cas_o && !mux_o && !busy_o));

    // R3
    mux_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
        mux_o |-> ras_o);

    // R3
    mux_lags_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mux_o) |-> $past(ras_o));

    // R4
    cas_after_mux_chk: assert property (@(posedge clk) disable iff (rst)
        cas_o |-> mux_o);

    // R6
    ras_under_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ras_o |-> busy_o);

    // R7
    precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_o) |-> (gap_cnt >= GW'(PRE_TICKS)));

endmodule

bind dram_strobe_seq dram_strobe_seq_chk #(
    .PRE_TICKS(PRE_TICKS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ras_o (ras_o),
    .cas_o (cas_o),
    .mux_o (mux_o),
    .busy_o(busy_o)
);

// File: tb/tb_dram_strobe_seq.sv
module tb_dram_strobe_seq;

    localparam int AW   = 8;
    localparam int T_MX = 2;
    localparam int T_RD = 4;
    localparam int T_WR = 5;
    localparam int T_EN = 12;
    localparam int LEN  = 15;

    typedef struct packed {
        logic          ras;
        logic          mux;
        logic          cas;
        logic          busy;
        logic          chk_addr;
        logic [AW-1:0] addr;
        logic [3:0]    tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe_i = 1'b0;
    logic rw_i = 1'b1;
    logic refresh_req_i = 1'b0;
    logic [AW-1:0] row_i = '0;
    logic [AW-1:0] col_i = '0;
    logic ras_o, cas_o, mux_o, busy_o;
    logic [AW-1:0] dram_addr_o;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    logic [AW-1:0] ref_model = '0;

    always #10 clk = ~clk;

    dram_strobe_seq dut (
        .clk          (clk),
        .rst          (rst),
        .strobe_i     (strobe_i),
        .rw_i         (rw_i),
        .refresh_req_i(refresh_req_i),
        .row_i        (row_i),
        .col_i        (col_i),
        .ras_o        (ras_o),
        .cas_o        (cas_o),
        .mux_o        (mux_o),
        .dram_addr_o  (dram_addr_o),
        .busy_o       (busy_o)
    );

    function automatic string req_name(input logic [3:0] t);
        case (t)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    function automatic exp_t idle_exp(input logic [3:0] tag);
        exp_t e;
        e = '0;
        e.tag = tag;
        return e;
    endfunction

    // Expected processor-cycle state at tick n; tag0 overrides the tick 0 tag.
    function automatic exp_t cpu_exp(input int n, input logic rd, input logic [AW-1:0] r,
                                     input logic [AW-1:0] c, input logic [3:0] tag0);
        exp_t e;
        int ct;
        ct = rd ? T_RD : T_WR;
        e.ras      = (n < T_EN);
        e.mux      = (n >= T_MX) && (n < T_EN);
        e.cas      = (n >= ct) && (n < T_EN);
        e.busy     = (n < LEN);
        e.chk_addr = 1'b1;
        e.addr     = e.mux ? c : r;
        if (n < T_MX)         e.tag = 4'd2;   // R2
        else if (n < T_RD)    e.tag = 4'd3;   // R3
        else if (n < T_EN)    e.tag = 4'd4;   // R4
        else if (n == T_EN)   e.tag = 4'd5;   // R5
        else                  e.tag = 4'd6;   // R6
        if (n == 0 && tag0 != 4'd0) e.tag = tag0;
        return e;
    endfunction

    // Expected refresh-cycle state at tick n (R8).
    function automatic exp_t ref_exp(input int n, input logic [AW-1:0] r, input logic [3:0] tag0);
        exp_t e;
        e.ras      = (n < T_EN);
        e.mux      = 1'b0;
        e.cas      = 1'b0;
        e.busy     = (n < LEN);
        e.chk_addr = 1'b1;
        e.addr     = r;
        e.tag      = (n == 0 && tag0 != 4'd0) ? tag0 : 4'd8;
        return e;
    endfunction

    // Driver: one expected item per clock edge, inputs change 5 ns after the edge.
    task automatic step(input exp_t e);
        @(posedge clk);
        q.push_back(e);
        #5;
    endtask

    task automatic cpu_cycle(input logic rd, input logic [AW-1:0] r, input logic [AW-1:0] c);
        strobe_i = 1'b1; rw_i = rd; row_i = r; col_i = c;
        for (int n = 0; n < LEN; n++) begin
            step(cpu_exp(n, rd, r, c, 4'd0));
            if (n == 2) strobe_i = 1'b0;
        end
        step(idle_exp(4'd6));
    endtask

    task automatic ref_cycle(input logic [3:0] tag0);
        refresh_req_i = 1'b1;
        for (int n = 0; n < LEN; n++) begin
            step(ref_exp(n, ref_model, tag0));
            refresh_req_i = 1'b0;
        end
        ref_model = ref_model + 1'b1;
        step(idle_exp(4'd6));
    endtask

    // Monitor: pops one expectation per cycle, sampled at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (ras_o !== e.ras || mux_o !== e.mux || cas_o !== e.cas || busy_o !== e.busy ||
                (e.chk_addr && dram_addr_o !== e.addr)) begin
                failures++;
                $display("FAIL %s: ras/mux/cas/busy/addr actual %b%b%b%b/%0d expected %b%b%b%b/%0d",
                         req_name(e.tag), ras_o, mux_o, cas_o, busy_o, dram_addr_o,
                         e.ras, e.mux, e.cas, e.busy, e.addr);
            end
        end
    end

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset clears everything
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (ras_o !== 1'b0 || cas_o !== 1'b0 || mux_o !== 1'b0 || busy_o !== 1'b0) begin
            failures++;
            $display("FAIL R1: outputs during reset actual %b%b%b%b expected 0000",
                     ras_o, mux_o, cas_o, busy_o);
        end
        rst = 1'b0;
        step(idle_exp(4'd1));
        step(idle_exp(4'd1));

        // R8 and R1: first refresh drives row 0
        ref_cycle(4'd1);

        // R2-R6: read then write
        cpu_cycle(1'b1, 8'h3C, 8'hA5);
        cpu_cycle(1'b0, 8'h81, 8'h18);

        // R2: held strobe does not retrigger
        strobe_i = 1'b1; rw_i = 1'b1; row_i = 8'h11; col_i = 8'h22;
        for (int n = 0; n < LEN; n++) step(cpu_exp(n, 1'b1, 8'h11, 8'h22, 4'd0));
        for (int n = 0; n < 4; n++) step(idle_exp(4'd2));
        strobe_i = 1'b0;
        step(idle_exp(4'd2));

        // R7: strobe edge during busy is queued and chained at tick 15
        strobe_i = 1'b1; rw_i = 1'b0; row_i = 8'h05; col_i = 8'h06;
        for (int n = 0; n < LEN; n++) begin
            step(cpu_exp(n, 1'b0, 8'h05, 8'h06, 4'd0));
            if (n == 2) strobe_i = 1'b0;
            if (n == 6) begin
                strobe_i = 1'b1; rw_i = 1'b1; row_i = 8'hF0; col_i = 8'h0F;
            end
        end
        for (int n = 0; n < LEN; n++) begin
            step(cpu_exp(n, 1'b1, 8'hF0, 8'h0F, 4'd7));
            if (n == 2) strobe_i = 1'b0;
        end
        step(idle_exp(4'd6));

        // R10: strobe and refresh in the same tick, refresh wins
        strobe_i = 1'b1; rw_i = 1'b0; row_i = 8'h77; col_i = 8'h99;
        refresh_req_i = 1'b1;
        for (int n = 0; n < LEN; n++) begin
            step(ref_exp(n, ref_model, 4'd10));
            refresh_req_i = 1'b0;
            if (n == 2) strobe_i = 1'b0;
        end
        ref_model = ref_model + 1'b1;
        for (int n = 0; n < LEN; n++) step(cpu_exp(n, 1'b0, 8'h77, 8'h99, 4'd10));
        step(idle_exp(4'd6));

        // R11: refresh raised mid-cycle waits for tick 15
        strobe_i = 1'b1; rw_i = 1'b1; row_i = 8'h42; col_i = 8'h24;
        for (int n = 0; n < LEN; n++) begin
            step(cpu_exp(n, 1'b1, 8'h42, 8'h24, 4'd0));
            if (n == 2) strobe_i = 1'b0;
            if (n == 3) refresh_req_i = 1'b1;
        end
        for (int n = 0; n < LEN; n++) begin
            step(ref_exp(n, ref_model, 4'd11));
            refresh_req_i = 1'b0;
        end
        ref_model = ref_model + 1'b1;
        step(idle_exp(4'd6));

        // R9: a full lap of refresh rows, including the wrap to 0
        for (int k = 0; k < 257; k++) ref_cycle(4'd9);

        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule